// File: doc/BRIEF.md
# Serial-Loaded Six-Channel DAC Code Register Bank

This block is the digital control front end for a bank of six 8-bit DAC cores. A host drives three serial wires (data, shift clock, strobe). The block shifts in a 15-bit frame, least significant bit first. The frame carries an 8-bit output code, a 3-bit channel address and a 4-bit device-match field. When the strobe rises, the code is written into the one addressed channel register. The write happens only if the match field agrees with the pattern chosen by the level on the chip-select pin, and the address names a real channel. This lets several devices share one strobe line: each device only accepts the frames whose match field fits its own chip-select strap.

The three serial wires are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges of the shift clock and strobe are detected in the system clock domain. A reset request from a supply monitor clears all six registers to zero scale. The six register values drive the DAC cores directly.

Top module: `serial_dac_bank`

## Requirements
- R1: After rst_ni is released, all six channel outputs read 0.
- R2: Frame bits are taken on rising edges of sclk_i, first bit first. After 15 bits, the first bit shifted is the code LSB and bits 1 to 8 form the 8-bit code.
- R3: Frame bits 9 to 11 form the channel address. The first of these bits is the address LSB. Address values 0 to 5 select chan_code_o[0] to chan_code_o[5].
- R4: A frame with address 6 or 7 changes no channel register.
- R5: Frame bits 12 to 15 form the match field, with bit 12 as its LSB. With cs_i low, a write needs the field to equal MATCH_LO (default 4'b0011). With cs_i high, it needs MATCH_HI (default 4'b1100). Any other value leaves all registers unchanged.
- R6: A write happens once, on the rising edge of strobe_i, and the value is kept after strobe falls. Clock pulses that arrive while strobe is held high cause no further write.
- R7: When mon_rst_i is high at a clock edge, all six channels become 0. This clear takes priority over a simultaneous write.
- R8: Only the most recent 15 shifted bits are used. Bits shifted before them are discarded.
- R9: A write to one channel leaves the other five channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial frame data (asynchronous) |
| sclk_i | input | 1 | Serial shift clock (asynchronous), data taken on its rising edge |
| strobe_i | input | 1 | Load strobe (asynchronous), write on its rising edge |
| cs_i | input | 1 | Chip-select strap level that selects the expected match pattern |
| mon_rst_i | input | 1 | Supply-monitor reset, clears all channels |
| chan_code_o | output | 6x8 | Per-channel DAC codes, packed [NUM_CH-1:0][CODE_W-1:0] |

## Verification
A strobe rising edge reaches the channel outputs on the third system clock edge. Two edges are spent in the synchronizer and one in the register write. A shift clock edge takes the same three edges to enter the shift register. The bench holds every serial level for four system clocks, and holds the strobe high for six clocks and low for six more before it samples at a falling clock edge. Every sample is therefore at least three cycles past the edge that caused it. A monitor reset is applied for one clock, and the outputs are sampled two falling edges later, after the single registered clear.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int unsigned DEF_NUM_CH  = 6;
  localparam int unsigned DEF_CODE_W  = 8;
  localparam int unsigned DEF_ADDR_W  = 3;
  localparam int unsigned DEF_MATCH_W = 4;
  localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift #(
  parameter int unsigned FRAME_W = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);
  // first bit shifted ends up at index 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      frame_o <= '0;
    else if (shift_i) frame_o <= {bit_i, frame_o[FRAME_W-1:1]};
  end
endmodule

// File: rtl/dac_frame_decode.sv
module dac_frame_decode #(
  parameter int unsigned          NUM_CH   = 6,
  parameter int unsigned          ADDR_W   = 3,
  parameter int unsigned          MATCH_W  = 4,
  parameter logic [MATCH_W-1:0]   MATCH_LO = 4'b0011,
  parameter logic [MATCH_W-1:0]   MATCH_HI = 4'b1100
) (
  input  logic               load_i,
  input  logic               cs_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [MATCH_W-1:0] match_i,
  output logic [NUM_CH-1:0]  we_o
);
  logic match_ok;
  logic hit;

  assign match_ok = cs_i ? (match_i == MATCH_HI) : (match_i == MATCH_LO);
  assign hit      = load_i && match_ok;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_we
    assign we_o[i] = hit && (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CODE_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic [NUM_CH-1:0]              we_i,
  input  logic [CODE_W-1:0]              code_i,
  output logic [NUM_CH-1:0][CODE_W-1:0]  chan_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      chan_o[i] <= '0;
      else if (clr_i)   chan_o[i] <= '0;
      else if (we_i[i]) chan_o[i] <= code_i;
    end
  end
endmodule

// File: rtl/serial_dac_bank.sv
module serial_dac_bank
  import dac_bank_pkg::*;
#(
  parameter int unsigned        NUM_CH   = DEF_NUM_CH,
  parameter int unsigned        CODE_W   = DEF_CODE_W,
  parameter int unsigned        ADDR_W   = DEF_ADDR_W,
  parameter int unsigned        MATCH_W  = DEF_MATCH_W,
  parameter int unsigned        SYNC     = DEF_SYNC,
  parameter logic [MATCH_W-1:0] MATCH_LO = 4'b0011,
  parameter logic [MATCH_W-1:0] MATCH_HI = 4'b1100
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sdata_i,
  input  logic                          sclk_i,
  input  logic                          strobe_i,
  input  logic                          cs_i,
  input  logic                          mon_rst_i,
  output logic [NUM_CH-1:0][CODE_W-1:0] chan_code_o
);
  localparam int unsigned FRAME_W = CODE_W + ADDR_W + MATCH_W;
  localparam int unsigned ADDR_LO = CODE_W;
  localparam int unsigned MATCH_LO_BIT = CODE_W + ADDR_W;

  logic [2:0]         lvl;
  logic               sclk_q, stb_q;
  logic               sclk_rise, stb_rise;
  logic [FRAME_W-1:0] frame_q;
  logic [NUM_CH-1:0]  we;

  dac_sync #(.W(3), .STAGES(SYNC)) u_sync (
    .clk_i, .rst_ni,
    .async_i ({strobe_i, sclk_i, sdata_i}),
    .sync_o  (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      sclk_q <= lvl[1];
      stb_q  <= lvl[2];
    end
  end

  assign sclk_rise = lvl[1] & ~sclk_q;
  assign stb_rise  = lvl[2] & ~stb_q;

  dac_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i, .rst_ni,
    .shift_i (sclk_rise),
    .bit_i   (lvl[0]),
    .frame_o (frame_q)
  );

  dac_frame_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .MATCH_W(MATCH_W),
    .MATCH_LO(MATCH_LO), .MATCH_HI(MATCH_HI)
  ) u_dec (
    .load_i  (stb_rise),
    .cs_i    (cs_i),
    .addr_i  (frame_q[ADDR_LO +: ADDR_W]),
    .match_i (frame_q[MATCH_LO_BIT +: MATCH_W]),
    .we_o    (we)
  );

  dac_chan_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_regs (
    .clk_i, .rst_ni,
    .clr_i  (mon_rst_i),
    .we_i   (we),
    .code_i (frame_q[CODE_W-1:0]),
    .chan_o (chan_code_o)
  );
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk #(
  parameter int unsigned        NUM_CH   = 6,
  parameter int unsigned        CODE_W   = 8,
  parameter int unsigned        ADDR_W   = 3,
  parameter int unsigned        MATCH_W  = 4,
  parameter logic [MATCH_W-1:0] MATCH_LO = 4'b0011,
  parameter logic [MATCH_W-1:0] MATCH_HI = 4'b1100
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic                                  mon_rst_i,
  input logic                                  cs_i,
  input logic                                  stb_rise,
  input logic [CODE_W+ADDR_W+MATCH_W-1:0]      frame_q,
  input logic [NUM_CH-1:0][CODE_W-1:0]         chan_code_o
);
  logic [CODE_W-1:0]  f_code;
  logic [ADDR_W-1:0]  f_addr;
  logic [MATCH_W-1:0] f_match;
  logic               f_match_ok;
  logic [NUM_CH-1:0][CODE_W-1:0] prev_q;
  logic               mon_q;
  logic [NUM_CH-1:0]  diff;

  assign f_code     = frame_q[CODE_W-1:0];
  assign f_addr     = frame_q[CODE_W +: ADDR_W];
  assign f_match    = frame_q[CODE_W+ADDR_W +: MATCH_W];
  assign f_match_ok = cs_i ? (f_match == MATCH_HI) : (f_match == MATCH_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      mon_q  <= 1'b0;
    end else begin
      prev_q <= chan_code_o;
      mon_q  <= mon_rst_i;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_diff
    assign diff[i] = (chan_code_o[i] != prev_q[i]);

    assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_rise && !mon_rst_i && f_match_ok && (f_addr == ADDR_W'(i))
      |=> chan_code_o[i] == $past(f_code));
  end

  assert_clear_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_rst_i |=> chan_code_o == '0);

  assert_no_write_without_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_rise && !mon_rst_i |=> $stable(chan_code_o));

  assert_single_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_rise |=> !stb_rise);

  assert_bad_addr_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_rise && !mon_rst_i && (int'(f_addr) >= NUM_CH) |=> $stable(chan_code_o));

  assert_match_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_rise && !mon_rst_i && !f_match_ok |=> $stable(chan_code_o));

  assert_one_channel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_q |-> $countones(diff) <= 1);
endmodule

bind serial_dac_bank dac_bank_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .MATCH_W(MATCH_W),
  .MATCH_LO(MATCH_LO), .MATCH_HI(MATCH_HI)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mon_rst_i   (mon_rst_i),
  .cs_i        (cs_i),
  .stb_rise    (stb_rise),
  .frame_q     (frame_q),
  .chan_code_o (chan_code_o)
);

// File: tb/sim_serial_dac_bank.sv
`timescale 1ns/1ps
module sim_serial_dac_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, strobe = 1'b0, cs = 1'b0, mon_rst = 1'b0;
  logic [5:0][7:0] chan;
  logic [7:0] exp_q [6];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_dac_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk),
    .strobe_i(strobe), .cs_i(cs), .mon_rst_i(mon_rst), .chan_code_o(chan)
  );

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [14:0] mk(input logic [3:0] m, input logic [2:0] a, input logic [7:0] c);
    return {m, a, c};
  endfunction

  task automatic shift_bit(input logic b);
    sdata = b;
    wait_n(4); sclk = 1'b1;
    wait_n(4); sclk = 1'b0;
    wait_n(4);
  endtask

  task automatic shift_frame(input logic [14:0] f);
    for (int i = 0; i < 15; i++) shift_bit(f[i]);
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1; wait_n(6);
    strobe = 1'b0; wait_n(6);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 6; i++) begin
      checks++;
      if (chan[i] !== exp_q[i]) begin
        errors++;
        $display("FAIL %s ch%0d actual %02h expected %02h", req, i, chan[i], exp_q[i]);
      end
    end
  endtask

  task automatic t_reset_r1();
    for (int i = 0; i < 6; i++) exp_q[i] = 8'h00;
    check_all("R1");
  endtask

  task automatic t_each_channel_r3();
    for (int i = 0; i < 6; i++) begin
      shift_frame(mk(4'b0011, 3'(i), 8'h11 * 8'(i + 1)));
      pulse_strobe();
      exp_q[i] = 8'h11 * 8'(i + 1);
      check_all("R3/R9");
    end
  endtask

  task automatic t_bit_order_r2();
    shift_frame(mk(4'b0011, 3'd2, 8'b1000_0001));
    pulse_strobe();
    exp_q[2] = 8'h81;
    check_all("R2");
    shift_frame(mk(4'b0011, 3'd2, 8'b0000_0110));
    pulse_strobe();
    exp_q[2] = 8'h06;
    check_all("R2");
  endtask

  task automatic t_bad_addr_r4();
    shift_frame(mk(4'b0011, 3'd6, 8'hEE)); pulse_strobe();
    check_all("R4");
    shift_frame(mk(4'b0011, 3'd7, 8'hDD)); pulse_strobe();
    check_all("R4");
  endtask

  task automatic t_match_r5();
    shift_frame(mk(4'b1100, 3'd0, 8'h5A)); pulse_strobe();
    check_all("R5 cs low wrong pattern");
    shift_frame(mk(4'b0000, 3'd0, 8'h5A)); pulse_strobe();
    check_all("R5 cs low zero pattern");
    cs = 1'b1; wait_n(2);
    shift_frame(mk(4'b0011, 3'd1, 8'hA5)); pulse_strobe();
    check_all("R5 cs high wrong pattern");
    shift_frame(mk(4'b1100, 3'd1, 8'hA5)); pulse_strobe();
    exp_q[1] = 8'hA5;
    check_all("R5 cs high match");
    cs = 1'b0; wait_n(2);
  endtask

  task automatic t_held_strobe_r6();
    shift_frame(mk(4'b0011, 3'd4, 8'h3C));
    strobe = 1'b1; wait_n(6);
    exp_q[4] = 8'h3C;
    check_all("R6 write at strobe rise");
    shift_frame(mk(4'b0011, 3'd4, 8'hC3));
    strobe = 1'b0; wait_n(6);
    check_all("R6 single write while held");
  endtask

  task automatic t_extra_bits_r8();
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    shift_frame(mk(4'b0011, 3'd5, 8'h42));
    pulse_strobe();
    exp_q[5] = 8'h42;
    check_all("R8");
  endtask

  task automatic t_mon_clear_r7();
    @(negedge clk); mon_rst = 1'b1;
    @(negedge clk); mon_rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 6; i++) exp_q[i] = 8'h00;
    check_all("R7 clear");
    shift_frame(mk(4'b0011, 3'd3, 8'h77));
    strobe = 1'b1; wait_n(2);
    mon_rst = 1'b1; wait_n(3);
    mon_rst = 1'b0; wait_n(1);
    check_all("R7 clear beats write");
    strobe = 1'b0; wait_n(6);
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    t_reset_r1();
    t_each_channel_r3();
    t_bit_order_r2();
    t_bad_addr_r4();
    t_match_r5();
    t_held_strobe_r6();
    t_extra_bits_r8();
    t_mon_clear_r7();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule